// File: doc/BRIEF.md
# Depth Direction Tracking Controller

This controller decides whether a coarse, low-resolution depth buffer may still be used to reject fragments early during a render pass. A coarse buffer built with one comparison sense cannot serve the other, so the block remembers which comparison direction has been used by depth-writing draws. When it sees two directions that cannot be combined, it turns rejection off until the state is explicitly cleared.

A coarse buffer covers only one layer and one mip level of a depth target. For that reason the block also stores the depth-view descriptor that the buffer was built for: a layer index, a mip level and a base identifier. Every draw, and every start of a pass that reuses the buffer, must present a descriptor equal to the stored one. Any difference disables rejection.

An optional bidirectional mode assumes that a separate coarse buffer exists for each direction. In that mode a direction change does not disable anything. It switches which of the two buffers is selected instead.

Top module: `depth_dir_tracker`

## Requirements
- R1: After reset, `dir_o` is 2'b00 (unknown), `enable_o` is 1 and `buf_sel_o` is 0.
- R2: While the direction is unknown, a `draw_i` strobe with `zwrite_i`=1 and a matching view sets `dir_o` to 2'b10 when `greater_i`=1 and to 2'b01 when `greater_i`=0, starting at the next clock edge.
- R3: A `draw_i` strobe with `zwrite_i`=0 and a matching view leaves `dir_o`, `enable_o` and `buf_sel_o` unchanged, whatever `greater_i` is.
- R4: With `bidir_i`=0, a depth-writing draw whose direction differs from the one already set makes `dir_o` 2'b11 (invalid) and `enable_o` 0. That state persists through later draws and pass starts until `clear_i`.
- R5: A depth-writing draw whose direction equals the one already set leaves the state unchanged and `enable_o` at 1.
- R6: A `clear_i` pulse sets `dir_o` to 2'b00, `enable_o` to 1 and `buf_sel_o` to 0 at the next clock edge. In the same edge it loads the view presented on the view inputs as the stored descriptor.
- R7: A `pass_start_i` pulse with a view equal to the stored one keeps the current direction, so the buffer is reused. A pulse with any field different makes `dir_o` 2'b11 and `enable_o` 0.
- R8: A draw strobe whose layer, mip level or base identifier differs from the stored descriptor makes `dir_o` 2'b11 and `enable_o` 0, whether or not the draw writes depth.
- R9: With `bidir_i`=1, a depth-writing draw with a new direction moves `dir_o` to that direction and keeps `enable_o` at 1. `buf_sel_o` follows the direction of the last depth-writing draw that set the direction: 1 for greater, 0 for less.
- R10: When strobes coincide, `clear_i` takes priority over `pass_start_i`, and `pass_start_i` takes priority over `draw_i`. The lower-priority strobe is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Clear state and capture the current view |
| pass_start_i | input | 1 | Start of a pass that reuses the coarse buffer |
| draw_i | input | 1 | Draw strobe |
| zwrite_i | input | 1 | Draw writes depth |
| greater_i | input | 1 | Draw compares with greater (1) or less (0) |
| bidir_i | input | 1 | Bidirectional mode (0 = off) |
| view_layer_i | input | LAYER_W | Depth-view layer index |
| view_mip_i | input | MIP_W | Depth-view mip level |
| view_base_i | input | BASE_W | Depth-view base identifier |
| dir_o | output | 2 | Direction state: 00 unknown, 01 less, 10 greater, 11 invalid |
| enable_o | output | 1 | Coarse rejection allowed |
| buf_sel_o | output | 1 | Selected per-direction buffer |

## Verification
Draw sequences are fed with a single direction, with a later conflicting direction, and with depth writes switched off. These separate first-write capture, same-direction hold, the sticky invalid state and the no-write case. Views are perturbed one field at a time, through both pass starts and draws, which shows that layer, mip and base each take part in the match. The same alternating-direction sequence is repeated with the bidirectional mode on, to distinguish buffer switching from invalidation. Coincident strobes expose the priority order.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
    typedef enum logic [1:0] {
        DIR_UNKNOWN = 2'b00,
        DIR_LESS    = 2'b01,
        DIR_GREATER = 2'b10,
        DIR_INVALID = 2'b11
    } dir_e;
endpackage

// File: rtl/ddt_view_cmp.sv
module ddt_view_cmp #(
    parameter int LAYER_W = 11,
    parameter int MIP_W   = 4,
    parameter int BASE_W  = 24
) (
    input  logic [LAYER_W-1:0] cur_layer_i,
    input  logic [MIP_W-1:0]   cur_mip_i,
    input  logic [BASE_W-1:0]  cur_base_i,
    input  logic [LAYER_W-1:0] ref_layer_i,
    input  logic [MIP_W-1:0]   ref_mip_i,
    input  logic [BASE_W-1:0]  ref_base_i,
    output logic               match_o
);
    localparam int TOT_W = LAYER_W + MIP_W + BASE_W;

    logic [TOT_W-1:0] cur_flat;
    logic [TOT_W-1:0] ref_flat;
    logic [TOT_W-1:0] bit_eq;

    assign cur_flat = {cur_layer_i, cur_mip_i, cur_base_i};
    assign ref_flat = {ref_layer_i, ref_mip_i, ref_base_i};

    for (genvar g = 0; g < TOT_W; g++) begin : g_bit
        assign bit_eq[g] = ~(cur_flat[g] ^ ref_flat[g]);
    end

    assign match_o = &bit_eq;
endmodule

// File: rtl/ddt_dir_next.sv
module ddt_dir_next
    import ddt_pkg::*;
(
    input  dir_e cur_dir_i,
    input  logic cur_buf_i,
    input  logic clear_i,
    input  logic pass_start_i,
    input  logic draw_i,
    input  logic zwrite_i,
    input  logic greater_i,
    input  logic bidir_i,
    input  logic view_ok_i,
    output dir_e nxt_dir_o,
    output logic nxt_buf_o
);
    dir_e want;

    always_comb begin
        want      = greater_i ? DIR_GREATER : DIR_LESS;
        nxt_dir_o = cur_dir_i;
        nxt_buf_o = cur_buf_i;
        if (clear_i) begin
            nxt_dir_o = DIR_UNKNOWN;
            nxt_buf_o = 1'b0;
        end else if (pass_start_i) begin
            if (!view_ok_i) nxt_dir_o = DIR_INVALID;
        end else if (draw_i) begin
            if (!view_ok_i) begin
                nxt_dir_o = DIR_INVALID;
            end else if (zwrite_i && cur_dir_i != DIR_INVALID) begin
                if (cur_dir_i == DIR_UNKNOWN) begin
                    nxt_dir_o = want;
                    nxt_buf_o = greater_i;
                end else if (cur_dir_i != want) begin
                    if (bidir_i) begin
                        nxt_dir_o = want;
                        nxt_buf_o = greater_i;
                    end else begin
                        nxt_dir_o = DIR_INVALID;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/depth_dir_tracker.sv
module depth_dir_tracker
    import ddt_pkg::*;
#(
    parameter int LAYER_W = 11,
    parameter int MIP_W   = 4,
    parameter int BASE_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               pass_start_i,
    input  logic               draw_i,
    input  logic               zwrite_i,
    input  logic               greater_i,
    input  logic               bidir_i,
    input  logic [LAYER_W-1:0] view_layer_i,
    input  logic [MIP_W-1:0]   view_mip_i,
    input  logic [BASE_W-1:0]  view_base_i,
    output logic [1:0]         dir_o,
    output logic               enable_o,
    output logic               buf_sel_o
);
    typedef struct packed {
        dir_e               dir;
        logic               en;
        logic               bsel;
        logic [LAYER_W-1:0] layer;
        logic [MIP_W-1:0]   mip;
        logic [BASE_W-1:0]  base;
    } state_t;

    state_t st_d, st_q;
    logic   view_ok;
    dir_e   dir_nxt;
    logic   buf_nxt;

    ddt_view_cmp #(
        .LAYER_W(LAYER_W), .MIP_W(MIP_W), .BASE_W(BASE_W)
    ) u_cmp (
        .cur_layer_i(view_layer_i),
        .cur_mip_i  (view_mip_i),
        .cur_base_i (view_base_i),
        .ref_layer_i(st_q.layer),
        .ref_mip_i  (st_q.mip),
        .ref_base_i (st_q.base),
        .match_o    (view_ok)
    );

    ddt_dir_next u_next (
        .cur_dir_i   (st_q.dir),
        .cur_buf_i   (st_q.bsel),
        .clear_i     (clear_i),
        .pass_start_i(pass_start_i),
        .draw_i      (draw_i),
        .zwrite_i    (zwrite_i),
        .greater_i   (greater_i),
        .bidir_i     (bidir_i),
        .view_ok_i   (view_ok),
        .nxt_dir_o   (dir_nxt),
        .nxt_buf_o   (buf_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.dir  = dir_nxt;
        st_d.bsel = buf_nxt;
        st_d.en   = (dir_nxt != DIR_INVALID);
        if (clear_i) begin
            st_d.layer = view_layer_i;
            st_d.mip   = view_mip_i;
            st_d.base  = view_base_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= DIR_UNKNOWN;
            st_q.en    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o     = st_q.dir;
    assign enable_o  = st_q.en;
    assign buf_sel_o = st_q.bsel;

    // R4
    invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_INVALID && !clear_i) |=> (st_q.dir == DIR_INVALID));

    // R4
    invalid_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_INVALID) |-> !enable_o);

    // R6
    clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.dir == DIR_UNKNOWN && enable_o && !buf_sel_o));

    // R3
    nowrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_i && !zwrite_i && view_ok && !clear_i && !pass_start_i)
        |=> $stable(st_q.dir));

    // R2
    first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_UNKNOWN && draw_i && zwrite_i && view_ok && !clear_i && !pass_start_i)
        |=> (st_q.dir == (($past(greater_i)) ? DIR_GREATER : DIR_LESS)));

    // R9
    bidir_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir_i && draw_i && zwrite_i && view_ok && !clear_i && !pass_start_i
         && st_q.dir != DIR_INVALID) |=> enable_o);

    // R8
    view_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_i && !view_ok && !clear_i) |=> !enable_o);
endmodule

// File: tb/depth_dir_tracker_bench.sv
module depth_dir_tracker_bench;
    localparam int LW = 11;
    localparam int MW = 4;
    localparam int BW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 0, pass_start_i = 0, draw_i = 0, zwrite_i = 0, greater_i = 0, bidir_i = 0;
    logic [LW-1:0] layer_i = '0;
    logic [MW-1:0] mip_i = '0;
    logic [BW-1:0] base_i = '0;
    logic [1:0] dir_o;
    logic enable_o, buf_sel_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    depth_dir_tracker #(.LAYER_W(LW), .MIP_W(MW), .BASE_W(BW)) u_depth_dir_tracker (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .pass_start_i(pass_start_i),
        .draw_i(draw_i), .zwrite_i(zwrite_i), .greater_i(greater_i), .bidir_i(bidir_i),
        .view_layer_i(layer_i), .view_mip_i(mip_i), .view_base_i(base_i),
        .dir_o(dir_o), .enable_o(enable_o), .buf_sel_o(buf_sel_o)
    );

    task automatic check(string req, logic [1:0] ed, logic ee, logic eb);
        n_cmp++;
        if (dir_o !== ed || enable_o !== ee || buf_sel_o !== eb) begin
            n_bad++;
            $display("FAIL %s: got dir=%b en=%b buf=%b, expected dir=%b en=%b buf=%b",
                     req, dir_o, enable_o, buf_sel_o, ed, ee, eb);
        end
    endtask

    task automatic set_view(int l, int m, int b);
        layer_i = LW'(l); mip_i = MW'(m); base_i = BW'(b);
    endtask

    // one-cycle strobe, outputs valid at the following negedge
    task automatic strobe(bit c, bit p, bit d, bit w, bit g);
        @(negedge clk);
        clear_i = c; pass_start_i = p; draw_i = d; zwrite_i = w; greater_i = g;
        @(negedge clk);
        clear_i = 0; pass_start_i = 0; draw_i = 0; zwrite_i = 0; greater_i = 0;
    endtask

    task automatic t_reset;
        check("R1 reset", 2'b00, 1'b1, 1'b0);
    endtask

    task automatic t_single_dir;
        set_view(5, 2, 'h1234);
        strobe(1, 0, 0, 0, 0);
        check("R6 clear", 2'b00, 1, 0);
        strobe(0, 0, 1, 1, 0);
        check("R2 first less", 2'b01, 1, 0);
        strobe(0, 0, 1, 0, 1);
        check("R3 no write", 2'b01, 1, 0);
        strobe(0, 0, 1, 1, 0);
        check("R5 same dir", 2'b01, 1, 0);
        strobe(0, 0, 1, 1, 1);
        check("R4 conflict", 2'b11, 0, 0);
        strobe(0, 0, 1, 1, 0);
        check("R4 sticky draw", 2'b11, 0, 0);
        strobe(0, 1, 0, 0, 0);
        check("R4 sticky pass", 2'b11, 0, 0);
        strobe(1, 0, 0, 0, 0);
        check("R6 clear from invalid", 2'b00, 1, 0);
        strobe(0, 0, 1, 1, 1);
        check("R2 first greater", 2'b10, 1, 1);
    endtask

    task automatic t_reuse;
        strobe(0, 1, 0, 0, 0);
        check("R7 pass match", 2'b10, 1, 1);
        set_view(5, 3, 'h1234);
        strobe(0, 1, 0, 0, 0);
        check("R7 pass mip miss", 2'b11, 0, 1);
        set_view(9, 1, 'h55);
        strobe(1, 0, 0, 0, 0);
        strobe(0, 0, 1, 1, 0);
        check("R6 view loaded", 2'b01, 1, 0);
        set_view(8, 1, 'h55);
        strobe(0, 0, 1, 1, 0);
        check("R8 layer miss", 2'b11, 0, 0);
        strobe(1, 0, 0, 0, 0);
        set_view(8, 1, 'h56);
        strobe(0, 0, 1, 0, 0);
        check("R8 base miss nowrite", 2'b11, 0, 0);
        set_view(8, 1, 'h55);
        strobe(1, 0, 0, 0, 0);
    endtask

    task automatic t_bidir;
        bidir_i = 1;
        strobe(0, 0, 1, 1, 0);
        check("R9 bidir less", 2'b01, 1, 0);
        strobe(0, 0, 1, 1, 1);
        check("R9 bidir greater", 2'b10, 1, 1);
        strobe(0, 0, 1, 1, 0);
        check("R9 bidir back", 2'b01, 1, 0);
        bidir_i = 0;
    endtask

    task automatic t_priority;
        strobe(1, 0, 1, 1, 1);
        check("R10 clear over draw", 2'b00, 1, 0);
        strobe(0, 0, 1, 1, 0);
        strobe(0, 1, 1, 1, 1);
        check("R10 pass over draw", 2'b01, 1, 0);
        set_view(1, 1, 1);
        strobe(1, 1, 0, 0, 0);
        check("R10 clear over pass", 2'b00, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single_dir();
        t_reuse();
        t_bidir();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule